// File: doc/BRIEF.md
# Local Memory Decoder with External Bus Fallback

This block sits between an 8-bit processor with a 16-bit address space and three memory targets: a read-only region on the board, a RAM region on the board, and a port to an external system bus. Each byte request goes to exactly one of these targets. The choice depends on the address and on two enable bits held in a control register. The read-only region wins over RAM where the two overlap. An address that no enabled region claims goes to the external port, which uses a valid/ready handshake. A write that lands in the enabled read-only region is discarded. It is reported by a one-cycle flag together with the address of the write.

A front end accepts byte or 16-bit word requests. A word becomes two byte cycles: the low byte at the given address, then the high byte at the next address, which wraps modulo 2^16. Each byte is decoded separately, so one word can touch two different targets. The two bytes are returned together as one 16-bit response. The memory arrays are outside the block. The block drives their strobes and offsets and takes their combinational read data.

Two state machines make up the design.
- The front end has the states `W_IDLE`, `W_LO`, `W_HI` and `W_RESP`, with these transitions:
  - accept: `W_IDLE`→`W_LO`
  - low done, byte request: `W_LO`→`W_RESP`
  - low done, word request: `W_LO`→`W_HI`
  - high done: `W_HI`→`W_RESP`
  - respond: `W_RESP`→`W_IDLE`
- The byte engine has the states `B_IDLE`, `B_EXT` and `B_DONE`, with these transitions:
  - local or dropped access: `B_IDLE`→`B_DONE`
  - external access: `B_IDLE`→`B_EXT`
  - ready seen: `B_EXT`→`B_DONE`
  - complete: `B_DONE`→`B_IDLE`

Top module: `local_mem_decoder`

## Requirements
- R1: After reset the control register holds 0b11, so both regions are enabled. `req_ready` is 1. `rsp_valid`, `wdrop_pulse` and every memory and external strobe are 0.
- R2: When `cfg_en[0]` is set, a read whose address lies in [ROM_BASE, ROM_BASE+4096) pulses `rom_rd` once, with `rom_addr` = address − ROM_BASE. It returns `rom_rdata` in `rsp_rdata[7:0]`, and `rsp_rdata[15:8]` is 0 for a byte access.
- R3: When `cfg_en[1]` is set and the read-only region does not claim the address, an access in [0x3C00, 0x4000) uses the RAM port. A read pulses `ram_rd` and returns `ram_rdata`. A write pulses `ram_we` with `ram_wdata` at offset address − 0x3C00.
- R4: Decode priority is fixed: read-only region first, then RAM, then the external port. Where the regions overlap and both are enabled, the read-only region is selected.
- R5: When a region's enable bit is clear, an access inside that region goes to the external port.
- R6: A write to the enabled read-only region pulses no RAM or external strobe. Exactly one `wdrop_pulse` cycle follows, with `wdrop_addr` equal to the write address.
- R7: `ext_valid` stays high, with `ext_addr`, `ext_write` and `ext_wdata` stable, until `ext_ready` is seen. A read returns the `ext_rdata` present in that cycle.
- R8: `rsp_valid` is high for exactly one cycle. For a request whose bytes are all local or dropped, it rises after the 2nd clock edge following the accepting edge (byte) or after the 4th (word).
- R9: With `req_word`=1, the low byte is accessed at A and the high byte at A+1 mod 2^16. The response is {high, low}, and a write sends `req_wdata[7:0]` to A and `req_wdata[15:8]` to A+1.
- R10: Each byte of a word is decoded on its own, so a word that crosses a region edge sends each byte to its own target.
- R11: `req_ready` is 0 from the accepting edge until the response cycle ends. No new request is taken meanwhile.
- R12: A cycle with `cfg_wr`=1 loads `cfg_en` into the control register. This takes effect for requests accepted afterwards.
- R13: Region ends are exclusive. With default parameters, 0x0FFF is in the read-only region, 0x1000 and 0x3BFF go external, 0x3C00 and 0x3FFF are RAM, and 0x4000 goes external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the control register |
| cfg_en | input | 2 | Enable bits: [0] read-only region, [1] RAM region |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| req_ready | output | 1 | Front end idle; a request is taken on this edge |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result {high, low} |
| rom_rd | output | 1 | Read strobe to the read-only array |
| rom_addr | output | 12 | Offset into the read-only array |
| rom_rdata | input | 8 | Combinational read data from the read-only array |
| ram_rd | output | 1 | Read strobe to RAM |
| ram_we | output | 1 | Write strobe to RAM |
| ram_addr | output | 10 | Offset into RAM |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | Combinational read data from RAM |
| ext_valid | output | 1 | External bus request |
| ext_write | output | 1 | External bus direction |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_ready | input | 1 | External bus completion |
| ext_rdata | input | 8 | External bus read data |
| wdrop_pulse | output | 1 | One-cycle flag for a discarded read-only write |
| wdrop_addr | output | 16 | Address of the last discarded write |

## Verification
Local strobes are combinational in the cycle after acceptance. The response to a local byte arrives two edges after the accepting edge, and to a local word four edges after. The bench counts negative edges from acceptance and expects the response at count 3 or 5, and it reads `req_ready` at count 1. External accesses have no fixed latency, because the bench's bus model delays `ext_ready` by an address-dependent number of cycles. For those, the bench waits for `rsp_valid` and then compares the data and the logged bus transfers. Strobe counts are sampled on rising edges. After every access they are compared with the counts that the address and the enable bits predict.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [1:0] {
        TGT_ROM = 2'd0,
        TGT_RAM = 2'd1,
        TGT_EXT = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        B_IDLE = 2'd0,
        B_EXT  = 2'd1,
        B_DONE = 2'd2
    } byte_st_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_LO   = 2'd1,
        W_HI   = 2'd2,
        W_RESP = 2'd3
    } word_st_e;

endpackage

// File: rtl/mdec_region_match.sv
module mdec_region_match #(
    parameter int AW   = 16,
    parameter int BASE = 0,
    parameter int SIZE = 4096,
    parameter int OW   = $clog2(SIZE)
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [OW-1:0] offset
);
    localparam logic [AW:0] LO_BOUND = (AW+1)'(BASE);
    localparam logic [AW:0] HI_BOUND = (AW+1)'(BASE + SIZE);

    logic [AW:0]   addr_w;
    logic [AW-1:0] diff;

    assign addr_w = {1'b0, addr};
    assign diff   = addr - AW'(BASE);
    assign hit    = en && (addr_w >= LO_BOUND) && (addr_w < HI_BOUND);
    assign offset = diff[OW-1:0];

endmodule

// File: rtl/mdec_byte_engine.sv
module mdec_byte_engine
    import mdec_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int ROM_BASE = 0,
    parameter int ROM_SIZE = 4096,
    parameter int RAM_BASE = 16'h3C00,
    parameter int RAM_SIZE = 1024,
    parameter int ROM_AW   = $clog2(ROM_SIZE),
    parameter int RAM_AW   = $clog2(RAM_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        en,
    input  logic              go,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DW-1:0]     rom_rdata,
    output logic              ram_rd,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ext_valid,
    output logic              ext_write,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_wdata,
    input  logic              ext_ready,
    input  logic [DW-1:0]     ext_rdata,
    output logic              drop_pulse,
    output logic [AW-1:0]     drop_addr
);
    byte_st_e      st_q, st_d;
    tgt_e          tgt;
    logic          rom_hit, ram_hit;
    logic          take;
    logic [AW-1:0] xa_q;
    logic          xw_q;
    logic [DW-1:0] xd_q;
    logic [DW-1:0] rd_q;
    logic          drop_q;
    logic [AW-1:0] drop_a_q;

    mdec_region_match #(.AW(AW), .BASE(ROM_BASE), .SIZE(ROM_SIZE), .OW(ROM_AW)) rom_match (
        .en(en[0]), .addr(addr), .hit(rom_hit), .offset(rom_addr)
    );

    mdec_region_match #(.AW(AW), .BASE(RAM_BASE), .SIZE(RAM_SIZE), .OW(RAM_AW)) ram_match (
        .en(en[1]), .addr(addr), .hit(ram_hit), .offset(ram_addr)
    );

    always_comb begin
        if (rom_hit)      tgt = TGT_ROM;
        else if (ram_hit) tgt = TGT_RAM;
        else              tgt = TGT_EXT;
    end

    assign take = (st_q == B_IDLE) && go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= B_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            B_IDLE: if (go) st_d = (tgt == TGT_EXT) ? B_EXT : B_DONE;
            B_EXT:  if (ext_ready) st_d = B_DONE;
            B_DONE: st_d = B_IDLE;
            default: st_d = B_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xa_q     <= '0;
            xw_q     <= 1'b0;
            xd_q     <= '0;
            rd_q     <= '0;
            drop_q   <= 1'b0;
            drop_a_q <= '0;
        end else begin
            drop_q <= take && (tgt == TGT_ROM) && wr;
            if (take) begin
                xa_q <= addr;
                xw_q <= wr;
                xd_q <= wdata;
                if (wr)                  rd_q <= '0;
                else if (tgt == TGT_ROM) rd_q <= rom_rdata;
                else if (tgt == TGT_RAM) rd_q <= ram_rdata;
                if (tgt == TGT_ROM && wr) drop_a_q <= addr;
            end else if (st_q == B_EXT && ext_ready) begin
                rd_q <= xw_q ? '0 : ext_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        rom_rd     = take && (tgt == TGT_ROM) && !wr;
        ram_rd     = take && (tgt == TGT_RAM) && !wr;
        ram_we     = take && (tgt == TGT_RAM) && wr;
        ram_wdata  = wdata;
        ext_valid  = (st_q == B_EXT);
        ext_write  = xw_q;
        ext_addr   = xa_q;
        ext_wdata  = xd_q;
        done       = (st_q == B_DONE);
        rdata      = rd_q;
        drop_pulse = drop_q;
        drop_addr  = drop_a_q;
    end

endmodule

// File: rtl/mdec_word_front.sv
module mdec_word_front
    import mdec_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [AW-1:0]   req_addr,
    input  logic [2*DW-1:0] req_wdata,
    output logic            req_ready,
    output logic            rsp_valid,
    output logic [2*DW-1:0] rsp_rdata,
    output logic            b_go,
    output logic            b_wr,
    output logic [AW-1:0]   b_addr,
    output logic [DW-1:0]   b_wdata,
    input  logic            b_done,
    input  logic [DW-1:0]   b_rdata
);
    word_st_e        st_q, st_d;
    logic [AW-1:0]   a_q;
    logic [2*DW-1:0] d_q;
    logic            wr_q, word_q;
    logic [DW-1:0]   lo_q, hi_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= W_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE: if (req_valid) st_d = W_LO;
            W_LO:   if (b_done) st_d = word_q ? W_HI : W_RESP;
            W_HI:   if (b_done) st_d = W_RESP;
            W_RESP: st_d = W_IDLE;
            default: st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            d_q    <= '0;
            wr_q   <= 1'b0;
            word_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (st_q == W_IDLE && req_valid) begin
                a_q    <= req_addr;
                d_q    <= req_wdata;
                wr_q   <= req_write;
                word_q <= req_word;
                hi_q   <= '0;
            end
            if (st_q == W_LO && b_done) lo_q <= b_rdata;
            if (st_q == W_HI && b_done) hi_q <= b_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready = (st_q == W_IDLE);
        rsp_valid = (st_q == W_RESP);
        rsp_rdata = {hi_q, lo_q};
        b_go      = (st_q == W_LO) || (st_q == W_HI);
        b_wr      = wr_q;
        b_addr    = (st_q == W_HI) ? a_q + AW'(1) : a_q;
        b_wdata   = (st_q == W_HI) ? d_q[2*DW-1:DW] : d_q[DW-1:0];
    end

endmodule

// File: rtl/local_mem_decoder.sv
module local_mem_decoder
    import mdec_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int ROM_BASE = 0,
    parameter int ROM_SIZE = 4096,
    parameter int RAM_BASE = 16'h3C00,
    parameter int RAM_SIZE = 1024,
    parameter int ROM_AW   = $clog2(ROM_SIZE),
    parameter int RAM_AW   = $clog2(RAM_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [2*DW-1:0]   req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [2*DW-1:0]   rsp_rdata,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DW-1:0]     rom_rdata,
    output logic              ram_rd,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ext_valid,
    output logic              ext_write,
    output logic [AW-1:0]     ext_addr,
    output logic [DW-1:0]     ext_wdata,
    input  logic              ext_ready,
    input  logic [DW-1:0]     ext_rdata,
    output logic              wdrop_pulse,
    output logic [AW-1:0]     wdrop_addr
);
    logic [1:0]    en_q;
    logic          b_go, b_wr, b_done;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 2'b11;
        else if (cfg_wr) en_q <= cfg_en;
    end

    mdec_word_front #(.AW(AW), .DW(DW)) front (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .b_go(b_go), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_done(b_done), .b_rdata(b_rdata)
    );

    mdec_byte_engine #(
        .AW(AW), .DW(DW), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
        .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
    ) engine (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .go(b_go), .wr(b_wr), .addr(b_addr), .wdata(b_wdata),
        .done(b_done), .rdata(b_rdata),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_rd(ram_rd), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ext_valid(ext_valid), .ext_write(ext_write), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
        .drop_pulse(wdrop_pulse), .drop_addr(wdrop_addr)
    );

endmodule

// File: rtl/local_mem_decoder_chk.sv
module local_mem_decoder_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rom_rd,
    input logic          ram_rd,
    input logic          ram_we,
    input logic          ext_valid,
    input logic          ext_ready,
    input logic          ext_write,
    input logic [AW-1:0] ext_addr,
    input logic [DW-1:0] ext_wdata,
    input logic          wdrop_pulse
);
    // R7
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr)
                                    && $stable(ext_write) && $stable(ext_wdata));

    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_rd, ram_rd, ram_we, ext_valid}));

    // R6
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdrop_pulse |=> !wdrop_pulse);

    // R6
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdrop_pulse |-> !ram_we && !ext_valid);

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R8
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind local_mem_decoder local_mem_decoder_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rom_rd(rom_rd), .ram_rd(ram_rd), .ram_we(ram_we),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .wdrop_pulse(wdrop_pulse)
);

// File: tb/local_mem_decoder_test.sv
module local_mem_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_en = 2'b11;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rom_rd, ram_rd, ram_we, ext_valid, ext_write, wdrop_pulse;
    logic [11:0] rom_addr;
    logic [9:0]  ram_addr;
    logic [7:0]  ram_wdata, rom_rdata, ram_rdata, ext_wdata, ext_rdata;
    logic [15:0] ext_addr, wdrop_addr;
    logic        ext_ready = 1'b0;

    logic        ovl_valid = 1'b0;
    logic        o_rom_rd, o_ram_rd, o_ram_we, o_ext_valid, o_ext_write, o_drop;
    logic        o_ready, o_rsp;
    logic [15:0] o_rdata, o_ext_addr, o_drop_addr;
    logic [11:0] o_rom_addr;
    logic [9:0]  o_ram_addr;
    logic [7:0]  o_ram_wdata, o_ext_wdata;

    int checks = 0, errors = 0, cycles = 0, ext_lat = 0, ecnt = 0;
    int n_rom = 0, n_ramr = 0, n_ramw = 0, n_ext = 0, n_drop = 0;
    int o_nrom = 0, o_nram = 0, o_next = 0;
    logic [15:0] ext_wa [4];
    logic [7:0]  ext_wd [4];
    logic [15:0] last_drop = '0;
    logic [7:0]  ram_m [1024];
    logic [7:0]  ram_s [1024];
    logic [1:0]  en_cur = 2'b11;

    always #4 clk = ~clk;

    function automatic logic [7:0] rom_val(input logic [11:0] o);
        return o[7:0] ^ {o[11:8], o[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] ext_val(input logic [15:0] a);
        return a[15:8] + 8'(a[7:0] * 3) + 8'd1;
    endfunction

    // 0 = read-only region, 1 = RAM, 2 = external
    function automatic int tgt(input logic [15:0] a, input logic [1:0] en);
        if (en[0] && a < 16'h1000) return 0;
        if (en[1] && a >= 16'h3C00 && a < 16'h4000) return 1;
        return 2;
    endfunction

    assign rom_rdata = rom_val(rom_addr);
    assign ram_rdata = ram_m[ram_addr];
    assign ext_rdata = ext_val(ext_addr);

    local_mem_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_rd(ram_rd), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ext_valid(ext_valid), .ext_write(ext_write), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
        .wdrop_pulse(wdrop_pulse), .wdrop_addr(wdrop_addr)
    );

    // overlapping configuration: RAM at 0x0C00 inside the read-only region
    local_mem_decoder #(.RAM_BASE(16'h0C00)) uut_ovl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .req_valid(ovl_valid), .req_write(1'b0), .req_word(1'b0),
        .req_addr(req_addr), .req_wdata(16'h0000),
        .req_ready(o_ready), .rsp_valid(o_rsp), .rsp_rdata(o_rdata),
        .rom_rd(o_rom_rd), .rom_addr(o_rom_addr), .rom_rdata(8'h00),
        .ram_rd(o_ram_rd), .ram_we(o_ram_we), .ram_addr(o_ram_addr),
        .ram_wdata(o_ram_wdata), .ram_rdata(8'h00),
        .ext_valid(o_ext_valid), .ext_write(o_ext_write), .ext_addr(o_ext_addr),
        .ext_wdata(o_ext_wdata), .ext_ready(1'b1), .ext_rdata(8'h00),
        .wdrop_pulse(o_drop), .wdrop_addr(o_drop_addr)
    );

    // memory models and strobe monitors
    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            if (rom_rd) n_rom++;
            if (ram_rd) n_ramr++;
            if (ram_we) begin n_ramw++; ram_m[ram_addr] = ram_wdata; end
            if (ext_valid && ext_ready) begin
                if (ext_write) begin
                    ext_wa[n_ext % 4] = ext_addr;
                    ext_wd[n_ext % 4] = ext_wdata;
                end
                n_ext++;
            end
            if (wdrop_pulse) begin n_drop++; last_drop = wdrop_addr; end
            if (o_rom_rd) o_nrom++;
            if (o_ram_rd) o_nram++;
            if (o_ext_valid) o_next++;
        end
    end

    // external bus: ready after ext_lat waiting cycles
    always @(negedge clk) begin
        if (!ext_valid) begin
            ecnt = 0;
            ext_ready = 1'b0;
        end else begin
            ext_ready = (ecnt >= ext_lat);
            ecnt++;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = e;
        @(negedge clk);
        cfg_wr = 1'b0;
        en_cur = e;
    endtask

    task automatic access(input logic wr, input logic wd, input logic [15:0] a,
                          input logic [15:0] d, output logic [15:0] rd,
                          output int lat, output logic rdy_early);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdy_early = req_ready;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        @(negedge clk);
    endtask

    task automatic do_check(input logic wr, input logic wd, input logic [15:0] a,
                            input logic [15:0] d, input string tag);
        int s_rom = n_rom, s_rr = n_ramr, s_rw = n_ramw, s_ext = n_ext, s_drop = n_drop;
        int e_rom = 0, e_rr = 0, e_rw = 0, e_ext = 0, e_drop = 0;
        int nb = wd ? 2 : 1;
        int lat;
        bit all_local = 1'b1;
        logic rdy;
        logic [15:0] got, exp_rd = '0, last_rom_w = '0;
        for (int j = 0; j < nb; j++) begin
            logic [15:0] ba = a + 16'(j);
            case (tgt(ba, en_cur))
                0: if (wr) begin e_drop++; last_rom_w = ba; end
                   else begin e_rom++; exp_rd[8*j +: 8] = rom_val(ba[11:0]); end
                1: if (wr) e_rw++;
                   else begin e_rr++; exp_rd[8*j +: 8] = ram_s[10'(ba - 16'h3C00)]; end
                default: begin
                    e_ext++; all_local = 1'b0;
                    if (!wr) exp_rd[8*j +: 8] = ext_val(ba);
                end
            endcase
        end
        access(wr, wd, a, d, got, lat, rdy);
        chk(!rdy, "R11", "req_ready while busy", longint'(rdy), 0);
        chk({n_rom - s_rom, n_ramr - s_rr, n_ramw - s_rw, n_ext - s_ext, n_drop - s_drop}
            == {e_rom, e_rr, e_rw, e_ext, e_drop}, tag, "target strobes",
            longint'(a), longint'({e_rom[3:0], e_rr[3:0], e_rw[3:0], e_ext[3:0], e_drop[3:0]}));
        if (all_local)
            chk(lat == (wd ? 5 : 3), "R8", "local latency", lat, wd ? 5 : 3);
        if (!wr) begin
            chk(got == exp_rd, tag, "read data", got, exp_rd);
        end else begin
            int k = 0;
            for (int j = 0; j < nb; j++) begin
                logic [15:0] ba = a + 16'(j);
                logic [7:0]  bd = d[8*j +: 8];
                case (tgt(ba, en_cur))
                    1: begin
                        chk(ram_m[10'(ba - 16'h3C00)] == bd, tag, "ram write",
                            ram_m[10'(ba - 16'h3C00)], bd);
                        ram_s[10'(ba - 16'h3C00)] = bd;
                    end
                    2: begin
                        chk(ext_wa[(s_ext + k) % 4] == ba && ext_wd[(s_ext + k) % 4] == bd,
                            "R7", "external write", {ext_wa[(s_ext + k) % 4], ext_wd[(s_ext + k) % 4]},
                            {ba, bd});
                        k++;
                    end
                    default: ;
                endcase
            end
            if (e_drop > 0)
                chk(last_drop == last_rom_w, "R6", "dropped address", last_drop, last_rom_w);
        end
    endtask

    task automatic ovl_probe(input logic [1:0] e, input logic [15:0] a, input int exp);
        int s0 = o_nrom, s1 = o_nram, s2 = o_next;
        set_cfg(e);
        @(negedge clk);
        ovl_valid = 1'b1; req_addr = a;
        @(negedge clk);
        ovl_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk({o_nrom - s0, o_nram - s1, o_next - s2} ==
            {(exp == 0) ? 1 : 0, (exp == 1) ? 1 : 0, (exp == 2) ? 1 : 0},
            "R4", "overlap priority", longint'(e), exp);
    endtask

    initial begin
        logic [15:0] bnd [8];
        string tags [4];
        bnd = '{16'h0000, 16'h0FFF, 16'h1000, 16'h3BFF, 16'h3C00, 16'h3FFF, 16'h4000, 16'hFFFF};
        tags = '{"R5", "R2", "R3", "R12"};
        for (int i = 0; i < 1024; i++) begin
            ram_m[i] = 8'(i * 7 + 3);
            ram_s[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready && !rsp_valid && !rom_rd && !ram_rd && !ram_we && !ext_valid && !wdrop_pulse,
            "R1", "reset outputs", {req_ready, rsp_valid, rom_rd, ram_rd, ram_we, ext_valid}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !wdrop_pulse, "R1", "idle after reset",
            {req_ready, rsp_valid, wdrop_pulse}, 3'b100);
        do_check(1'b0, 1'b0, 16'h0010, '0, "R1");
        do_check(1'b0, 1'b0, 16'h3C10, '0, "R1");

        // byte read sweep under every enable setting
        for (int e = 0; e < 4; e++) begin
            set_cfg(2'(e));
            for (int a = 0; a < 65536; a += 251) begin
                ext_lat = a % 3;
                do_check(1'b0, 1'b0, 16'(a), '0, tags[e]);
            end
            for (int b = 0; b < 8; b++) do_check(1'b0, 1'b0, bnd[b], '0, "R13");
        end

        // byte write sweep
        for (int e = 0; e < 4; e += 3) begin
            set_cfg(2'(e));
            for (int a = 7; a < 65536; a += 509) begin
                ext_lat = a % 4;
                do_check(1'b1, 1'b0, 16'(a), 16'(a * 5 + 1), (tgt(16'(a), en_cur) == 0) ? "R6" : "R3");
            end
            for (int b = 0; b < 8; b++) do_check(1'b1, 1'b0, bnd[b], 16'(b + 8'hC0), "R13");
            for (int b = 0; b < 8; b++) do_check(1'b0, 1'b0, bnd[b], '0, "R3");
        end

        // word accesses, including region-crossing and wrap-around
        for (int e = 0; e < 4; e++) begin
            set_cfg(2'(e));
            for (int b = 0; b < 8; b++) begin
                ext_lat = b % 2;
                do_check(1'b0, 1'b1, bnd[b], '0, "R10");
                do_check(1'b1, 1'b1, bnd[b], 16'hBE00 + 16'(b * 17), "R10");
                do_check(1'b0, 1'b1, bnd[b], '0, "R9");
            end
            for (int a = 3; a < 65536; a += 1021) begin
                do_check(1'b0, 1'b1, 16'(a), '0, "R9");
                do_check(1'b1, 1'b1, 16'(a), 16'(a ^ 16'h5AA5), "R9");
            end
            do_check(1'b0, 1'b1, 16'h0FFE, '0, "R9");
        end

        // priority in an overlapping configuration
        ovl_probe(2'b11, 16'h0C10, 0);
        ovl_probe(2'b10, 16'h0C10, 1);
        ovl_probe(2'b00, 16'h0C10, 2);
        ovl_probe(2'b11, 16'h0BFF, 0);

        finish_run();
    end

endmodule